// File: doc/BRIEF.md
# Port Event Flag Register

This block keeps one sticky event flag per port line for a keyboard-style input group. Each line passes through a two-flop synchroniser and is compared against a per-line trigger level. While a line is enabled and sits at its trigger level, its flag is set by hardware. Software is the only agent that clears a flag. A level-sensitive interrupt request is raised while any enabled flag is set.

Software reaches three registers through a small strobe bus. The flag register is at address 0. The enable register is at address 1. The trigger-level register is at address 2. The bus tells plain accesses apart from read-modify-write accesses. A read-modify-write is a read phase, with `bus_rmw` high on the read strobe, followed later by a write-back, with `bus_rmw` high on the write strobe. A line may fire inside that window. Its flag then survives a write-back of zero, so the event is not lost. Each flag keeps a shadow bit that records whether it was set after the most recent read-modify-write read.

Top module: `port_event_flags`

## Requirements
- R1: An enabled line that holds its trigger level for at least 2 clock cycles sets its flag. The flag is visible three rising edges after the input change.
- R2: Trigger-level register bit i = 1 makes line i active-high; bit i = 0 makes it active-low. A line at its inactive level never sets its flag.
- R3: A line whose enable bit (address 1) is 0 never sets its flag, whatever its input does.
- R4: A set flag stays set until software writes to the flag register; a pulse on the input that has ended leaves it set.
- R5: A plain write to address 0 (`bus_rmw` = 0) clears every flag whose data bit is 0. It keeps every flag whose data bit is 1.
- R6: A read-modify-write write-back of 0 clears a flag that was already set at the read phase.
- R7: A read-modify-write write-back of 0 leaves set a flag that was set after the read phase and before the write phase.
- R8: When hardware sets a flag in the same cycle that software clears it, the set wins. So a flag whose line is still held at its trigger level cannot be cleared.
- R9: `irq` is a registered output. It is high one cycle after any flag whose enable bit is 1 is set. It is low one cycle after no such flag remains.
- R10: Reads are registered. `bus_rdata` shows the addressed register one edge after `bus_rd`. Address 3 reads as 0. `bus_rdata` holds its value while no read is made.
- R11: Synchronous reset clears the flags, shadow bits, enables, levels, synchroniser, `bus_rdata` and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | WIDTH | Asynchronous port lines |
| bus_addr | input | 2 | Register address: 0 flags, 1 enable, 2 level |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rmw | input | 1 | Marks the strobe as a read-modify-write phase |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Registered read data |
| irq | output | 1 | Level interrupt request |

## Verification
An input change reaches the flag register on the third rising edge after it is driven. It reaches `irq` on the fourth. Write strobes take effect on the next edge. Read data appears on the edge that follows the read strobe. The bench drives inputs on falling edges and holds each pulse for two rising edges. It reads flags only after at least four edges have passed, and it reads `irq` at least two edges after the last flag change. Every sample is therefore taken once the full register chain has settled. The bench sweeps every line under both trigger levels.

// File: rtl/pef_pkg.sv
package pef_pkg;
  typedef enum logic [1:0] {
    PEF_A_FLAG = 2'd0,
    PEF_A_EN   = 2'd1,
    PEF_A_LVL  = 2'd2,
    PEF_A_NONE = 2'd3
  } pef_addr_e;
endpackage

// File: rtl/pef_sync.sv
module pef_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/pef_detect.sv
module pef_detect #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] line_i,
  input  logic [WIDTH-1:0] en_i,
  input  logic [WIDTH-1:0] lvl_i,
  output logic [WIDTH-1:0] hit_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    assign hit_o[g] = en_i[g] & ~(line_i[g] ^ lvl_i[g]);
  end
endmodule

// File: rtl/pef_flags.sv
module pef_flags #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] set_i,
  input  logic             rd_rmw_i,
  input  logic             wr_plain_i,
  input  logic             wr_rmw_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] flags_o
);
  logic [WIDTH-1:0] flags_q, shadow_q, clr_mask;

  always_comb begin
    clr_mask = '0;
    if (wr_plain_i)    clr_mask = ~wdata_i;
    else if (wr_rmw_i) clr_mask = ~wdata_i & ~shadow_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q  <= '0;
      shadow_q <= '0;
    end else begin
      flags_q <= (flags_q & ~clr_mask) | set_i;
      if (rd_rmw_i) shadow_q <= set_i;
      else          shadow_q <= shadow_q | set_i;
    end
  end

  assign flags_o = flags_q;

  AST_HW_SET: assert property (@(posedge clk) disable iff (rst)
    (|set_i) |=> ((flags_q & $past(set_i)) == $past(set_i))); // R1
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_plain_i || wr_rmw_i) |=> ((flags_q & $past(flags_q)) == $past(flags_q))); // R4
  AST_PLAIN_CLR: assert property (@(posedge clk) disable iff (rst)
    wr_plain_i |=> ((flags_q & ~$past(wdata_i) & ~$past(set_i)) == '0)); // R5
  AST_RMW_KEEP: assert property (@(posedge clk) disable iff (rst)
    wr_rmw_i |=> ((flags_q & $past(shadow_q & flags_q)) == $past(shadow_q & flags_q))); // R7
endmodule

// File: rtl/port_event_flags.sv
module port_event_flags #(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] pin_in,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic             bus_rmw,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  output logic             irq
);
  import pef_pkg::*;

  logic [WIDTH-1:0] line_s, hit, flags, en_q, lvl_q, rdata_q;
  logic             irq_q;
  pef_addr_e        addr;

  assign addr = pef_addr_e'(bus_addr);

  pef_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(line_s)
  );

  pef_detect #(.WIDTH(WIDTH)) u_detect (
    .line_i(line_s), .en_i(en_q), .lvl_i(lvl_q), .hit_o(hit)
  );

  pef_flags #(.WIDTH(WIDTH)) u_flags (
    .clk(clk), .rst(rst), .set_i(hit),
    .rd_rmw_i(bus_rd && bus_rmw && addr == PEF_A_FLAG),
    .wr_plain_i(bus_wr && !bus_rmw && addr == PEF_A_FLAG),
    .wr_rmw_i(bus_wr && bus_rmw && addr == PEF_A_FLAG),
    .wdata_i(bus_wdata), .flags_o(flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= '0;
      lvl_q   <= '0;
      rdata_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= |(flags & en_q);
      if (bus_wr && addr == PEF_A_EN)  en_q  <= bus_wdata;
      if (bus_wr && addr == PEF_A_LVL) lvl_q <= bus_wdata;
      if (bus_rd) begin
        case (addr)
          PEF_A_FLAG: rdata_q <= flags;
          PEF_A_EN:   rdata_q <= en_q;
          PEF_A_LVL:  rdata_q <= lvl_q;
          default:    rdata_q <= '0;
        endcase
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = irq_q;

  AST_IRQ_ON: assert property (@(posedge clk) disable iff (rst)
    (|(flags & en_q)) |=> irq); // R9
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    ((flags & en_q) == '0) |=> !irq); // R9
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R10
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (bus_rdata == '0 && !irq)); // R11
endmodule

// File: tb/port_event_flags_test.sv
module port_event_flags_test;
  localparam int W = 8;
  logic clk = 1'b0, rst = 1'b1;
  logic [W-1:0] pins = '0, wdata = '0;
  logic [1:0] addr = '0;
  logic wr = 1'b0, rd = 1'b0, rmw = 1'b0;
  logic [W-1:0] rdata;
  logic irq;
  int checks = 0, errors = 0;
  logic [W-1:0] got;

  always #2.5 clk = ~clk;

  port_event_flags #(.WIDTH(W)) uut (
    .clk(clk), .rst(rst), .pin_in(pins), .bus_addr(addr), .bus_wr(wr),
    .bus_rd(rd), .bus_rmw(rmw), .bus_wdata(wdata), .bus_rdata(rdata), .irq(irq)
  );

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [W-1:0] d, input logic m);
    addr = a; wdata = d; rmw = m; wr = 1'b1;
    tick(1);
    wr = 1'b0; rmw = 1'b0;
  endtask

  task automatic bread(input logic [1:0] a, input logic m, output logic [W-1:0] d);
    addr = a; rmw = m; rd = 1'b1;
    tick(1);
    rd = 1'b0; rmw = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input int i, input logic act);
    pins[i] = act;
    tick(2);
    pins[i] = ~act;
    tick(4);
  endtask

  task automatic setup(input logic [W-1:0] lvl, input logic [W-1:0] en);
    bwrite(2'd1, '0, 1'b0);
    bwrite(2'd2, lvl, 1'b0);
    pins = ~lvl;
    tick(4);
    bwrite(2'd0, '0, 1'b0);
    bwrite(2'd1, en, 1'b0);
    tick(2);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    check("R11 irq", {7'd0, irq}, 8'h00);
    check("R11 rdata", rdata, 8'h00);
    bread(2'd0, 1'b0, got); check("R11 flags", got, 8'h00);
    bread(2'd1, 1'b0, got); check("R11 enable", got, 8'h00);

    // R1 R2 R5 R9 sweep: every line, both trigger levels
    for (int p = 0; p < 2; p++) begin
      for (int i = 0; i < W; i++) begin
        logic [W-1:0] lvl;
        lvl = (p == 1) ? '1 : '0;
        setup(lvl, '1);
        bread(2'd0, 1'b0, got); check("R2 idle no set", got, 8'h00);
        pulse(i, lvl[i]);
        bread(2'd0, 1'b0, got); check("R1 pulse captured", got, 8'(1 << i));
        check("R9 irq high", {7'd0, irq}, 8'h01);
        bwrite(2'd0, ~8'(1 << i), 1'b0);
        bread(2'd0, 1'b0, got); check("R5 plain clear", got, 8'h00);
        tick(1);
        check("R9 irq low", {7'd0, irq}, 8'h00);
      end
    end

    // R2 mixed levels, all lines active together
    setup(8'hA5, '1);
    bread(2'd0, 1'b0, got); check("R2 mixed idle", got, 8'h00);
    pins = 8'hA5; tick(2); pins = 8'h5A; tick(4);
    bread(2'd0, 1'b0, got); check("R2 mixed all", got, 8'hFF);
    bwrite(2'd0, 8'h0F, 1'b0);
    bread(2'd0, 1'b0, got); check("R5 keep ones", got, 8'h0F);

    // R3 disabled line
    setup(8'hFF, 8'h0F);
    pulse(6, 1'b1);
    bread(2'd0, 1'b0, got); check("R3 disabled no set", got, 8'h00);
    check("R3 irq", {7'd0, irq}, 8'h00);

    // R9 mask, R4 persistence
    pulse(1, 1'b1);
    bwrite(2'd1, 8'h00, 1'b0);
    tick(2);
    check("R9 masked irq", {7'd0, irq}, 8'h00);
    bread(2'd0, 1'b0, got); check("R4 flag kept", got, 8'h02);

    // R6 R7 read-modify-write
    setup(8'hFF, 8'hFF);
    pulse(0, 1'b1); pulse(1, 1'b1);
    bread(2'd0, 1'b1, got); check("R6 rmw read", got, 8'h03);
    bwrite(2'd0, 8'h01, 1'b1);
    bread(2'd0, 1'b0, got); check("R6 rmw clear", got, 8'h01);
    bread(2'd0, 1'b1, got); check("R7 rmw read", got, 8'h01);
    pulse(4, 1'b1);
    bwrite(2'd0, 8'h00, 1'b1);
    bread(2'd0, 1'b0, got); check("R7 late event kept", got, 8'h10);

    // R8 held line
    setup(8'hFF, 8'hFF);
    pins[2] = 1'b1; tick(5);
    bwrite(2'd0, 8'h00, 1'b0);
    bread(2'd0, 1'b0, got); check("R8 set wins", got, 8'h04);
    tick(1);
    check("R8 irq held", {7'd0, irq}, 8'h01);
    pins[2] = 1'b0; tick(4);
    bwrite(2'd0, 8'h00, 1'b0);
    bread(2'd0, 1'b0, got); check("R8 released clear", got, 8'h00);

    // R10 readback
    bwrite(2'd1, 8'h5A, 1'b0);
    bwrite(2'd2, 8'hC3, 1'b0);
    bread(2'd1, 1'b0, got); check("R10 enable", got, 8'h5A);
    bread(2'd2, 1'b0, got); check("R10 level", got, 8'hC3);
    tick(3);
    check("R10 hold", rdata, 8'hC3);
    bread(2'd3, 1'b0, got); check("R10 addr3", got, 8'h00);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule